// File: doc/BRIEF.md
# Coherence Invalidation Queue Controller

This block sits between a private cache's line-state array and the system coherence bus. Other agents send invalidate requests for line addresses. The block acknowledges each request in the same cycle that it stores it in a small FIFO, and applies the invalidation to the local state array later. It drains one entry per cycle, and only on cycles when the core is not using the array port.

Acknowledging early opens a window in which the core can still hit a line that another agent has already been told is gone. The core reads the array directly and never searches the queue, so a read in that window returns the stale line. Two things close the window:
- A read barrier from the core. It completes only once the queue is empty.
- An outgoing coherence message. It is held back while any queued invalidation for the same address is still waiting.

Top module: `inval_queue_ctrl`

## Requirements
- R1: When `inv_valid` is high and the queue holds fewer than `DEPTH` entries, `inv_ack` is high in the same cycle and the address is stored as the youngest entry.
- R2: When the queue holds `DEPTH` entries, `inv_ack` stays low and the request is not stored, until a drain frees a slot.
- R3: On a cycle with a non-empty queue and `core_use` low, the oldest entry is drained. Entries leave in arrival order, one per cycle, and `arr_addr` shows the oldest queued address.
- R4: While `core_use` is high, no entry is drained and `arr_inv` stays low. A queued line therefore stays valid in the array and can be read stale.
- R5: A drained entry pulses `arr_inv` only if `arr_hit` reports the line present and valid. Otherwise the entry is retired with no pulse.
- R6: `msg_go` is high only when `msg_req` is high and no stored entry carries `msg_addr`. A matching message waits until the youngest matching entry has drained, and leaves in the cycle after that drain.
- R7: `bar_done` is high exactly when `bar_req` is high and the queue is empty.
- R8: Reset (`rst_n` low) empties the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_valid | input | 1 | Incoming invalidate request |
| inv_addr | input | AW | Line address to invalidate |
| inv_ack | output | 1 | Request accepted into the queue |
| core_use | input | 1 | Core owns the state-array port this cycle |
| arr_addr | output | AW | Address of the oldest queued entry, used for the array lookup |
| arr_hit | input | 1 | Array reports the line at `arr_addr` as present and valid |
| arr_inv | output | 1 | Invalidate the line at `arr_addr` this cycle |
| msg_req | input | 1 | An outgoing coherence message is waiting |
| msg_addr | input | AW | Line address of the outgoing message |
| msg_go | output | 1 | The outgoing message may leave this cycle |
| bar_req | input | 1 | Read-barrier request from the core |
| bar_done | output | 1 | Read barrier complete |

## Verification
The bench fills the queue with the core holding the port. It then checks the following corner cases:
- The extra request at full depth must go unacknowledged. A design with an off-by-one would accept it and overwrite the oldest entry.
- A message whose address matches the youngest of eight entries must wait through all eight drains. A design that compared only against the head, or that released the message too early, would let it out ahead of an older invalidation.
- Draining an absent or already-invalid line must retire the entry silently.
- A barrier must stay open while any entry remains, and again after a reset that empties a partly filled queue.

// File: rtl/inval_queue_ctrl.sv
module inval_queue_ctrl #(
  parameter int AW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inv_valid,
  input  logic [AW-1:0] inv_addr,
  output logic          inv_ack,
  input  logic          core_use,
  output logic [AW-1:0] arr_addr,
  input  logic          arr_hit,
  output logic          arr_inv,
  input  logic          msg_req,
  input  logic [AW-1:0] msg_addr,
  output logic          msg_go,
  input  logic          bar_req,
  output logic          bar_done
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    slot_addr [DEPTH];
  logic [DEPTH-1:0] slot_vld;
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic [DEPTH-1:0] match_vec;
  logic             full, empty, enq, deq;

  assign full     = (cnt == CW'(DEPTH));
  assign empty    = (cnt == '0);
  assign enq      = inv_valid && !full;
  assign deq      = !empty && !core_use;
  assign inv_ack  = enq;
  assign arr_addr = slot_addr[rd_ptr];
  assign arr_inv  = deq && arr_hit;
  assign bar_done = bar_req && empty;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      match_vec[i] = slot_vld[i] && (slot_addr[i] == msg_addr);
  end
  assign msg_go = msg_req && !(|match_vec);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      slot_vld <= '0;
    end else begin
      if (deq) begin
        slot_vld[rd_ptr] <= 1'b0;
        rd_ptr           <= bump(rd_ptr);
      end
      if (enq) begin
        slot_vld[wr_ptr]  <= 1'b1;
        slot_addr[wr_ptr] <= inv_addr;
        wr_ptr            <= bump(wr_ptr);
      end
      cnt <= cnt + CW'(enq) - CW'(deq);
    end
  end

  a_r1_ack_stores: assert property (@(posedge clk) disable iff (!rst_n)
    inv_ack |=> cnt != '0);
  a_r2_full_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH)) |-> !inv_ack);
  a_r3_one_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !core_use && !inv_ack) |=> cnt == $past(cnt) - CW'(1));
  a_r4_core_priority: assert property (@(posedge clk) disable iff (!rst_n)
    core_use |-> !arr_inv);
  a_r6_count_matches_slots: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_vld) == int'(cnt));
  a_r7_barrier_empty: assert property (@(posedge clk) disable iff (!rst_n)
    bar_done |-> (cnt == '0));
endmodule

// File: tb/sim_inval_queue_ctrl.sv
`timescale 1ns/1ps
module sim_inval_queue_ctrl;
  localparam int AW = 8;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic inv_valid = 0, core_use = 0, msg_req = 0, bar_req = 0;
  logic [AW-1:0] inv_addr = '0, msg_addr = '0;
  logic inv_ack, arr_inv, arr_hit, msg_go, bar_done;
  logic [AW-1:0] arr_addr;
  logic line_v [256];
  int errors = 0, checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  inval_queue_ctrl #(.AW(AW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .inv_valid(inv_valid), .inv_addr(inv_addr),
    .inv_ack(inv_ack), .core_use(core_use), .arr_addr(arr_addr),
    .arr_hit(arr_hit), .arr_inv(arr_inv), .msg_req(msg_req),
    .msg_addr(msg_addr), .msg_go(msg_go), .bar_req(bar_req),
    .bar_done(bar_done));

  assign arr_hit = line_v[arr_addr];
  always @(posedge clk) if (arr_inv) line_v[arr_addr] <= 1'b0;

  typedef struct packed {
    logic iv; logic [7:0] ia; logic cu; logic mr; logic [7:0] ma; logic br;
    logic eack; logic einv; logic [7:0] eaddr; logic ego; logic edone;
  } row_t;

  localparam row_t TBL [12] = '{
    '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
    '{1'b1, 8'h10, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0},
    '{1'b1, 8'h11, 1'b1, 1'b1, 8'h10, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b1, 1'b1, 8'h20, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b1, 8'h11, 1'b1, 1'b0, 1'b1, 8'h10, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b1, 8'h11, 1'b0, 1'b0, 1'b1, 8'h11, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b1, 8'h11, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1},
    '{1'b1, 8'h05, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
    '{1'b1, 8'h10, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic iv, input logic [7:0] ia, input logic cu,
                       input logic mr, input logic [7:0] ma, input logic br);
    @(negedge clk);
    inv_valid = iv; inv_addr = ia; core_use = cu;
    msg_req = mr; msg_addr = ma; bar_req = br;
    #2;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) line_v[i] = 1'b1;
    line_v[5] = 1'b0;
    repeat (3) @(posedge clk);
    drive(0, 0, 0, 0, 0, 0);
    chk("R8 reset ack", {15'd0, inv_ack}, 16'd0);
    chk("R8 reset inv", {15'd0, arr_inv}, 16'd0);
    rst_n = 1'b1;

    // table walk: R1 R3 R4 R5 R6 R7
    for (int k = 0; k < 12; k++) begin
      drive(TBL[k].iv, TBL[k].ia, TBL[k].cu, TBL[k].mr, TBL[k].ma, TBL[k].br);
      chk("R1 ack", {15'd0, inv_ack}, {15'd0, TBL[k].eack});
      chk("R4/R5 arr_inv", {15'd0, arr_inv}, {15'd0, TBL[k].einv});
      if (TBL[k].einv) chk("R3 drain addr", {8'd0, arr_addr}, {8'd0, TBL[k].eaddr});
      chk("R6 msg_go", {15'd0, msg_go}, {15'd0, TBL[k].ego});
      chk("R7 bar_done", {15'd0, bar_done}, {15'd0, TBL[k].edone});
    end

    // R2: fill to depth with core holding the port
    for (int k = 0; k < DEPTH; k++) begin
      drive(1, 8'h30 + 8'(k), 1, 0, 0, 0);
      chk("R1 fill ack", {15'd0, inv_ack}, 16'd1);
    end
    drive(1, 8'h50, 1, 0, 0, 1);
    chk("R2 full no ack", {15'd0, inv_ack}, 16'd0);
    chk("R7 full no done", {15'd0, bar_done}, 16'd0);

    // R6 + R3: message for youngest entry waits through all drains
    for (int k = 0; k < DEPTH; k++) begin
      drive(0, 0, 0, 1, 8'h37, 0);
      chk("R6 stalled", {15'd0, msg_go}, 16'd0);
      chk("R3 fifo inv", {15'd0, arr_inv}, 16'd1);
      chk("R3 fifo order", {8'd0, arr_addr}, {8'd0, 8'h30 + 8'(k)});
    end
    drive(0, 0, 0, 1, 8'h37, 1);
    chk("R6 released", {15'd0, msg_go}, 16'd1);
    chk("R7 done after drain", {15'd0, bar_done}, 16'd1);
    chk("R2 no overwrite extra", {15'd0, arr_inv}, 16'd0);

    // R8: reset clears a partly filled queue
    for (int k = 0; k < 3; k++) drive(1, 8'h60 + 8'(k), 1, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 1);
    chk("R7 partial no done", {15'd0, bar_done}, 16'd0);
    rst_n = 1'b0;
    @(posedge clk);
    drive(0, 0, 1, 1, 8'h61, 1);
    rst_n = 1'b1;
    #0;
    chk("R8 empty after reset", {15'd0, bar_done}, 16'd1);
    chk("R8 no match after reset", {15'd0, msg_go}, 16'd1);
    drive(0, 0, 0, 0, 0, 0);
    chk("R8 nothing drains", {15'd0, arr_inv}, 16'd0);
    finish_run();
  end
endmodule